// File: doc/BRIEF.md
# Asynchronous Microcontroller Register Port

This block lets an external microcontroller reach on-chip logic over a plain parallel bus that has no clock. The bus has a 4-bit address, 16 data bits, a read strobe and a write strobe. Both strobes are synchronized into the system clock. Each write takes effect once, on the synchronized rising edge of the write strobe, using the address and data that the microcontroller holds steady. During a read, the port drives the data bus only while the synchronized read strobe is high. The pad ring combines the split data pins into the bidirectional bus.

Every control goes through registers in a 16-entry space, including the launch of each single-word DMA transfer. A flag register gathers the following:
- a transfer-request bit. Firmware sets it, and hardware clears it when the word completes.
- mailbox bits. Logic sets them, and firmware clears them by writing 1.
- read-only status inputs.

Firmware may treat a clear request bit as proof that the last word has finished. For that reason the bit reads as set from the committed write until the completion pulse. The DMA engine and the host bus are outside this block. A done pulse and a word input take their place.

Top module: `mcu_reg_port`

## Requirements
- R1: After the active-low reset, the following all read zero: the request bit, the mailbox bits, the outgoing word and the captured word. The bus output enable is low.
- R2: A write commits exactly once per write strobe. It acts on the second clock edge after the first edge that samples the strobe high, and it uses the address and data present at that edge.
- R3: The data output enable goes high one edge after the first edge that samples the read strobe high, and it falls the same way after the strobe falls. While the enable is low, the data output is zero.
- R4: Address 0x0 is the flag register. Bit 0 is the transfer request, bits 7:4 are the mailbox bits, bits 15:8 are the live status inputs, and bits 3:1 read zero.
- R5: Writing 1 to bit 0 at 0x0 sets the transfer request, which then stays set until a done pulse. Writing 0 to bit 0 has no effect.
- R6: A done pulse clears the transfer request. If a done pulse and a committed set arrive on the same edge, the request ends up set.
- R7: A done pulse latches the word input into address 0x1. That register is read-only, and writes to it are ignored.
- R8: Address 0x2 is the outgoing word register. It can be written and read back, and it drives the outgoing word output.
- R9: A mailbox set input sets its bit. Writing 1 to that bit's position at 0x0 clears it, and writing 0 leaves it alone. If a set and a clear arrive on the same edge, the set wins.
- R10: Addresses 0x3 to 0xF read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcu_addr_i | input | 4 | Register address from the microcontroller |
| mcu_data_i | input | 16 | Write data from the bus |
| mcu_data_o | output | 16 | Read data toward the bus |
| mcu_data_oe_o | output | 1 | Drive enable for the data pads |
| mcu_rd_i | input | 1 | Read strobe, asynchronous |
| mcu_wr_i | input | 1 | Write strobe, asynchronous |
| status_i | input | STAT_W (8) | Live status bits shown in the flag register |
| mbox_set_i | input | MBOX_W (4) | Pulses that set the mailbox bits |
| mbox_o | output | MBOX_W (4) | Current mailbox bits |
| xfer_req_o | output | 1 | Transfer request toward the DMA engine |
| xfer_done_i | input | 1 | One-cycle pulse when a word completes |
| xfer_word_i | input | 16 | Completed word, valid with the done pulse |
| xfer_wdata_o | output | 16 | Outgoing word for the DMA engine |

## Verification
The bench builds the port with its default parameters: four mailbox bits and eight status bits. At these values every flag field, and each gap between the fields, is reachable in a 16-bit word. The bench times writes so that a committed set lands on the same edge as a done pulse or a mailbox set pulse. This exercises both priority rules, and it also covers the request bit holding across long idle gaps before completion.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_FLAG = 4'h0;
  localparam logic [ADDR_W-1:0] A_RXW  = 4'h1;
  localparam logic [ADDR_W-1:0] A_TXW  = 4'h2;

  // flag register field positions
  localparam int REQ_BIT  = 0;
  localparam int MBOX_LSB = 4;
  localparam int STAT_LSB = 8;
endpackage

// File: rtl/mcu_strobe_sync.sv
module mcu_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  // chain[STAGES] is one extra delay used only for edge detection
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], strobe_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];

  p_single_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mcu_reg_file.sv
module mcu_reg_file
  import mcu_port_pkg::*;
#(
  parameter int MBOX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [MBOX_W-1:0] mbox_set_i,
  output logic              req_o,
  output logic [MBOX_W-1:0] mbox_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic [DATA_W-1:0] tx_word_o
);
  logic flag_wr, tx_wr, set_req;
  logic req_q;
  logic [MBOX_W-1:0] mbox_q;
  logic [DATA_W-1:0] rx_q, tx_q;

  assign flag_wr = wr_en_i && (wr_addr_i == A_FLAG);
  assign tx_wr   = wr_en_i && (wr_addr_i == A_TXW);
  assign set_req = flag_wr && wr_data_i[REQ_BIT];

  // set beats done: a fresh launch must not be lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (set_req) req_q <= 1'b1;
    else if (done_i)  req_q <= 1'b0;
  end

  for (genvar i = 0; i < MBOX_W; i++) begin : g_mbox
    logic clr;
    assign clr = flag_wr && wr_data_i[MBOX_LSB+i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            mbox_q[i] <= 1'b0;
      else if (mbox_set_i[i]) mbox_q[i] <= 1'b1;
      else if (clr)           mbox_q[i] <= 1'b0;
    end
    p_mbox_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mbox_q[i] && !clr) |=> mbox_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      if (done_i) rx_q <= word_i;
      if (tx_wr)  tx_q <= wr_data_i;
    end
  end

  assign req_o     = req_q;
  assign mbox_o    = mbox_q;
  assign rx_word_o = rx_q;
  assign tx_word_o = tx_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !done_i) |=> req_q);
  p_req_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !set_req) |=> !req_q);
  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rx_q == $past(word_i)));
endmodule

// File: rtl/mcu_read_mux.sv
module mcu_read_mux
  import mcu_port_pkg::*;
#(
  parameter int MBOX_W = 4,
  parameter int STAT_W = 8
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  input  logic [MBOX_W-1:0] mbox_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] flag_w, sel;

  always_comb begin
    flag_w = '0;
    flag_w[REQ_BIT] = req_i;
    flag_w[MBOX_LSB +: MBOX_W] = mbox_i;
    flag_w[STAT_LSB +: STAT_W] = status_i;
  end

  always_comb begin
    unique case (addr_i)
      A_FLAG:  sel = flag_w;
      A_RXW:   sel = rx_word_i;
      A_TXW:   sel = tx_word_i;
      default: sel = '0;
    endcase
  end

  assign data_o = en_i ? sel : '0;
endmodule

// File: rtl/mcu_reg_port.sv
module mcu_reg_port
  import mcu_port_pkg::*;
#(
  parameter int MBOX_W    = 4,
  parameter int STAT_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mcu_addr_i,
  input  logic [DATA_W-1:0] mcu_data_i,
  output logic [DATA_W-1:0] mcu_data_o,
  output logic              mcu_data_oe_o,
  input  logic              mcu_rd_i,
  input  logic              mcu_wr_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [MBOX_W-1:0] mbox_set_i,
  output logic [MBOX_W-1:0] mbox_o,
  output logic              xfer_req_o,
  input  logic              xfer_done_i,
  input  logic [DATA_W-1:0] xfer_word_i,
  output logic [DATA_W-1:0] xfer_wdata_o
);
  logic rd_lvl, rd_rise, wr_lvl, wr_rise;
  logic req;
  logic [MBOX_W-1:0] mbox;
  logic [DATA_W-1:0] rx_word, tx_word;

  mcu_strobe_sync #(.STAGES(SYNC_STGS)) u_rd_sync (
    .clk_i, .rst_ni, .strobe_i(mcu_rd_i), .level_o(rd_lvl), .rise_o(rd_rise)
  );

  mcu_strobe_sync #(.STAGES(SYNC_STGS)) u_wr_sync (
    .clk_i, .rst_ni, .strobe_i(mcu_wr_i), .level_o(wr_lvl), .rise_o(wr_rise)
  );

  // address and data are held steady by the bus protocol around the strobe
  mcu_reg_file #(.MBOX_W(MBOX_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_rise), .wr_addr_i(mcu_addr_i), .wr_data_i(mcu_data_i),
    .done_i(xfer_done_i), .word_i(xfer_word_i), .mbox_set_i(mbox_set_i),
    .req_o(req), .mbox_o(mbox), .rx_word_o(rx_word), .tx_word_o(tx_word)
  );

  mcu_read_mux #(.MBOX_W(MBOX_W), .STAT_W(STAT_W)) u_rmux (
    .en_i(rd_lvl), .addr_i(mcu_addr_i), .req_i(req), .mbox_i(mbox),
    .status_i(status_i), .rx_word_i(rx_word), .tx_word_i(tx_word),
    .data_o(mcu_data_o)
  );

  assign mcu_data_oe_o = rd_lvl;
  assign mbox_o        = mbox;
  assign xfer_req_o    = req;
  assign xfer_wdata_o  = tx_word;

  logic unused_lvl;
  assign unused_lvl = wr_lvl ^ rd_rise;

  p_oe_follows_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcu_data_oe_o |-> $past(mcu_rd_i, 2));
  p_quiet_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcu_data_oe_o |-> (mcu_data_o == '0));
endmodule

// File: tb/mcu_reg_port_test.sv
`timescale 1ns/1ps
module mcu_reg_port_test;
  logic clk = 0, rst_ni = 0;
  logic [3:0]  addr = 0;
  logic [15:0] din = 0, dout;
  logic oe, rd = 0, wr = 0;
  logic [7:0]  status = 0;
  logic [3:0]  mset = 0, mbox;
  logic req, done = 0;
  logic [15:0] word = 0, wdata;

  int checks = 0, errors = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  mcu_reg_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .mcu_addr_i(addr), .mcu_data_i(din),
    .mcu_data_o(dout), .mcu_data_oe_o(oe), .mcu_rd_i(rd), .mcu_wr_i(wr),
    .status_i(status), .mbox_set_i(mset), .mbox_o(mbox),
    .xfer_req_o(req), .xfer_done_i(done), .xfer_word_i(word),
    .xfer_wdata_o(wdata)
  );

  // behavioural reference
  bit m_req;
  bit [3:0] m_mbox;
  bit [15:0] m_rx, m_tx;
  bit [2:0] h_wr, h_rd;

  function automatic bit [15:0] m_read(input bit [3:0] a);
    case (a)
      4'h0: return {status, m_mbox, 3'b000, m_req};
      4'h1: return m_rx;
      4'h2: return m_tx;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_req = 0; m_mbox = 0; m_rx = 0; m_tx = 0; h_wr = 0; h_rd = 0;
    end else begin
      bit commit;
      commit = h_wr[1] && !h_wr[2];
      if (commit && addr == 4'h0 && din[0]) m_req = 1;
      else if (done) m_req = 0;
      for (int i = 0; i < 4; i++)
        if (mset[i]) m_mbox[i] = 1;
        else if (commit && addr == 4'h0 && din[4+i]) m_mbox[i] = 0;
      if (done) m_rx = word;
      if (commit && addr == 4'h2) m_tx = din;
      h_wr = {h_wr[1:0], wr};
      h_rd = {h_rd[1:0], rd};
    end
    #1;
    chk("R5/R6 req", {15'h0, req}, {15'h0, m_req});
    chk("R9 mbox", {12'h0, mbox}, {12'h0, m_mbox});
    chk("R3 oe", {15'h0, oe}, {15'h0, h_rd[1]});
    chk("R3/R4 data", dout, h_rd[1] ? m_read(addr) : 16'h0);
    chk("R8 wdata", wdata, m_tx);
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic mcu_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d;
    @(negedge clk); wr = 1;
    repeat (4) @(negedge clk);
    wr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic mcu_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1;
    repeat (4) @(negedge clk);
    d = dout;
    rd = 0;
    repeat (4) @(negedge clk);
  endtask

  // write whose commit lands on the same edge as a done or mailbox pulse
  task automatic hit_write(input logic [15:0] d, input logic dn,
                           input logic [15:0] w, input logic [3:0] ms);
    @(negedge clk); addr = 4'h0; din = d;
    @(negedge clk); wr = 1;
    @(negedge clk);
    @(negedge clk); done = dn; word = w; mset = ms;
    @(negedge clk); done = 0; mset = 0;
    @(negedge clk); wr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [15:0] w);
    @(negedge clk); done = 1; word = w;
    @(negedge clk); done = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {15'h0, oe}, 16'h0);
    chk("R1 reset req", {15'h0, req}, 16'h0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk("R1 after reset mbox", {12'h0, mbox}, 16'h0);
    chk("R1 after reset wdata", wdata, 16'h0);

    mcu_write(4'h2, 16'h6DDB);
    mcu_read(4'h2, v);  chk("R8 readback", v, 16'h6DDB);
    chk("R8 wdata out", wdata, 16'h6DDB);

    mcu_write(4'h0, 16'h0001);
    mcu_read(4'h0, v);  chk("R5 req set", v, 16'h0001);
    repeat (20) @(negedge clk);
    chk("R5 req held", {15'h0, req}, 16'h1);
    pulse_done(16'hB66D);
    chk("R6 done clears", {15'h0, req}, 16'h0);
    mcu_read(4'h1, v);  chk("R7 captured", v, 16'hB66D);

    mcu_write(4'h0, 16'h0001);
    mcu_write(4'h0, 16'h0000);
    chk("R5 zero no effect", {15'h0, req}, 16'h1);
    pulse_done(16'hDBB6);
    mcu_write(4'h1, 16'h1234);
    mcu_read(4'h1, v);  chk("R7 read-only", v, 16'hDBB6);

    hit_write(16'h0001, 1'b1, 16'h0F0F, 4'h0);
    chk("R6 set wins", {15'h0, req}, 16'h1);
    pulse_done(16'h0F0F);

    @(negedge clk); mset = 4'b1010;
    @(negedge clk); mset = 0;
    chk("R9 set", {12'h0, mbox}, 16'hA);
    mcu_write(4'h0, 16'h0020);
    mcu_read(4'h0, v);  chk("R9 w1c", v, 16'h0080);
    mcu_write(4'h0, 16'h0000);
    chk("R9 zero no effect", {12'h0, mbox}, 16'h8);
    hit_write(16'h0080, 1'b0, 16'h0, 4'b1000);
    chk("R9 set wins", {12'h0, mbox}, 16'h8);
    mcu_write(4'h0, 16'h0080);
    chk("R9 cleared", {12'h0, mbox}, 16'h0);

    @(negedge clk); status = 8'hA5;
    mcu_write(4'h0, 16'h0001);
    mcu_read(4'h0, v);  chk("R4 layout", v, 16'hA501);
    pulse_done(16'h5555);

    mcu_write(4'h7, 16'hFFFF);
    mcu_read(4'h7, v);  chk("R10 unmapped read", v, 16'h0);
    mcu_read(4'hF, v);  chk("R10 top address", v, 16'h0);
    mcu_read(4'h2, v);  chk("R10 write ignored", v, 16'h6DDB);
    chk("R2 single commit req", {15'h0, req}, 16'h0);

    repeat (5) @(negedge clk);
    report();
  end
endmodule